// File: doc/BRIEF.md
# Four-Channel PCM Highway Framer

This block is the digital framing port between a four-channel voice codec core and a PCM highway. It moves 8-bit companded samples in both directions, using one shared bit clock and a separate frame sync for each direction. All highway inputs are treated as level signals that are synchronous to the block clock. Edges on them are found by comparing each input with its value one clock earlier.

A layout input picks one of two frame shapes. In lane layout (input at 1), every channel has its own data-in line and its own data-out line, and all four channels use the first 8-bit slot after the sync. In time-division layout (input at 0), the four channels share one frame of 32 bits. They are received on data-in line 4 and sent on data-out line 1, in channel order 1, 2, 3, 4. The core hands over four transmit samples, which are captured at the transmit sync. It receives four samples back, with a one-cycle valid strobe.

Each data output is modelled as an open-drain pin. It has an output-enable, and it reads as 1 (the pulled-up level) whenever it is released.

Top module: `pcm_port`

## Requirements
- R1: Every sample is 8 bits and travels most significant bit first. Channel n (n = 0..3) sits at bits [8n+7:8n] of both `tx_samples` and `rx_samples`.
- R2: A rising edge of `tx_sync` captures `tx_samples` and drives the first bit at once. After that, `dout` changes only on a rising edge of `bclk`, one bit per edge.
- R3: A rising edge of `rx_sync` starts a receive frame. Each following falling edge of `bclk` samples one data bit.
- R4: A data output is enabled only during its own slot bits. It is released (`dout_oe`=0, `dout`=1) at all other times, including from the first `bclk` rise after its last bit.
- R5: When `lanes_mode`=1, channel n is sent on `dout[n]` and received on `din[n]`. Every channel uses the 8 bits right after its sync.
- R6: When `lanes_mode`=0, channels 0 to 3 fill four consecutive 8-bit slots, channel 0 first. They are received on `din[3]` and sent on `dout[0]`, and `dout[3:1]` stay released.
- R7: Once the final bit of a receive frame is sampled, all four samples are updated together. `rx_valid` is then high for exactly one clock.
- R8: Bits that arrive after the last slot of a frame are ignored until the next sync rising edge. `rx_samples` keeps its value and `rx_valid` stays low.
- R9: A sync rising edge in the middle of a frame restarts that direction's bit counter. Transmit reloads the samples at that edge, and the cut-short receive frame produces no strobe.
- R10: The transmit and receive frames run independently, each from its own sync, and may be offset by any number of bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Highway bit clock, as a level sampled by `clk` |
| tx_sync | input | 1 | Transmit frame sync |
| rx_sync | input | 1 | Receive frame sync |
| lanes_mode | input | 1 | 1 selects the per-channel lane layout, 0 selects the time-division layout |
| din | input | 4 | Highway data inputs, one per channel lane |
| tx_samples | input | 32 | Four transmit samples from the core, channel n at [8n+7:8n] |
| dout | output | 4 | Highway data outputs, reading 1 when released |
| dout_oe | output | 4 | Open-drain output enables |
| rx_samples | output | 32 | Four received samples, channel n at [8n+7:8n] |
| rx_valid | output | 1 | One-cycle strobe when a full receive frame is ready |

## Verification
A transmit bit appears on `dout` one clock after the clock edge that sees the `bclk` rise, or the sync rise for the first bit. The bench therefore reads each output bit in the last clock of the high half of the bit period, when the value has long settled. A received frame sets `rx_samples` and `rx_valid` one clock after the edge that sees the falling `bclk` of its last bit. A monitor runs on the falling edge of `clk` and compares each strobe with the oldest entry in the expected queue. After each frame the bench checks that the queue is empty and that the samples stay unchanged through the trailing bits.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    LAYOUT_TDM   = 1'b0,
    LAYOUT_LANES = 1'b1
  } layout_e;

  // Number of bit periods in one frame for the chosen layout.
  function automatic int unsigned frame_bits(logic lanes, int unsigned ch, int unsigned sw);
    return lanes ? sw : ch * sw;
  endfunction
endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
  assign fall = ~sig & sig_q;
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx #(
  parameter int CH = 4,
  parameter int SW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             sync_rise,
  input  logic             lanes_mode,
  input  logic [CH*SW-1:0] tx_flat,
  output logic [CH-1:0]    dout,
  output logic [CH-1:0]    dout_oe
);
  import pcm_port_pkg::*;
  localparam int FW = CH * SW;
  localparam int CW = $clog2(FW);

  logic          active;
  logic          lanes_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;
  logic [FW-1:0] sh [CH];
  logic          frame_end;

  function automatic logic [FW-1:0] load_word(logic lanes, int lane, logic [FW-1:0] flat);
    logic [FW-1:0] w;
    w = '0;
    if (lanes) begin
      w[FW-1 -: SW] = flat[lane*SW +: SW];
    end else if (lane == 0) begin
      for (int c = 0; c < CH; c++) w[FW-1-c*SW -: SW] = flat[c*SW +: SW];
    end
    return w;
  endfunction

  assign last_idx  = CW'(frame_bits(lanes_q, CH, SW) - 1);
  assign frame_end = active & bclk_rise & ~sync_rise & (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      lanes_q <= 1'b0;
      cnt     <= '0;
      for (int l = 0; l < CH; l++) sh[l] <= '0;
    end else if (sync_rise) begin
      active  <= 1'b1;
      lanes_q <= lanes_mode;
      cnt     <= '0;
      for (int l = 0; l < CH; l++) sh[l] <= load_word(lanes_mode, l, tx_flat);
    end else if (active && bclk_rise) begin
      if (cnt == last_idx) active <= 1'b0;
      else                 cnt    <= cnt + 1'b1;
      for (int l = 0; l < CH; l++) sh[l] <= sh[l] << 1;
    end
  end

  for (genvar l = 0; l < CH; l++) begin : g_lane
    if (l == 0) begin : g_first
      assign dout_oe[l] = active;
    end else begin : g_other
      assign dout_oe[l] = active & lanes_q;
    end
    assign dout[l] = dout_oe[l] ? sh[l][FW-1] : 1'b1;
  end

  // R9
  tx_sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> (active && cnt == '0));
  // R4
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (dout_oe == '0 && dout == '1));
  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bclk_rise && !sync_rise) |=> $stable(dout));
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx #(
  parameter int CH = 4,
  parameter int SW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_fall,
  input  logic             sync_rise,
  input  logic             lanes_mode,
  input  logic [CH-1:0]    din,
  output logic [CH*SW-1:0] rx_flat,
  output logic             rx_valid
);
  import pcm_port_pkg::*;
  localparam int FW = CH * SW;
  localparam int CW = $clog2(FW);

  logic          active;
  logic          lanes_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;
  logic [FW-1:0] sh  [CH];
  logic [FW-1:0] nxt [CH];
  logic [FW-1:0] unpacked;
  logic          frame_done;

  for (genvar l = 0; l < CH; l++) begin : g_shift
    assign nxt[l] = {sh[l][FW-2:0], din[l]};
  end

  always_comb begin
    unpacked = '0;
    for (int c = 0; c < CH; c++) begin
      if (lanes_q) unpacked[c*SW +: SW] = nxt[c][SW-1:0];
      else         unpacked[c*SW +: SW] = nxt[CH-1][FW-1-c*SW -: SW];
    end
  end

  assign last_idx   = CW'(frame_bits(lanes_q, CH, SW) - 1);
  assign frame_done = active & bclk_fall & ~sync_rise & (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      lanes_q  <= 1'b0;
      cnt      <= '0;
      rx_flat  <= '0;
      rx_valid <= 1'b0;
      for (int l = 0; l < CH; l++) sh[l] <= '0;
    end else begin
      rx_valid <= frame_done;
      if (sync_rise) begin
        active  <= 1'b1;
        lanes_q <= lanes_mode;
        cnt     <= '0;
      end else if (active && bclk_fall) begin
        for (int l = 0; l < CH; l++) sh[l] <= nxt[l];
        if (cnt == last_idx) begin
          active  <= 1'b0;
          rx_flat <= unpacked;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7
  rx_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R3
  rx_sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> (active && cnt == '0));
  // R8
  rx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !sync_rise) |=> ($stable(rx_flat) && !rx_valid));
endmodule

// File: rtl/pcm_port.sv
module pcm_port #(
  parameter int CH = 4,
  parameter int SW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             tx_sync,
  input  logic             rx_sync,
  input  logic             lanes_mode,
  input  logic [CH-1:0]    din,
  input  logic [CH*SW-1:0] tx_samples,
  output logic [CH-1:0]    dout,
  output logic [CH-1:0]    dout_oe,
  output logic [CH*SW-1:0] rx_samples,
  output logic             rx_valid
);
  logic bclk_rise, bclk_fall;
  logic txs_rise, txs_fall;
  logic rxs_rise, rxs_fall;

  pcm_edge_det u_bclk_edge (.clk(clk), .rst_n(rst_n), .sig(bclk),
                            .rise(bclk_rise), .fall(bclk_fall));
  pcm_edge_det u_txs_edge  (.clk(clk), .rst_n(rst_n), .sig(tx_sync),
                            .rise(txs_rise), .fall(txs_fall));
  pcm_edge_det u_rxs_edge  (.clk(clk), .rst_n(rst_n), .sig(rx_sync),
                            .rise(rxs_rise), .fall(rxs_fall));

  pcm_tx #(.CH(CH), .SW(SW)) u_tx (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .sync_rise(txs_rise),
    .lanes_mode(lanes_mode), .tx_flat(tx_samples), .dout(dout), .dout_oe(dout_oe));

  pcm_rx #(.CH(CH), .SW(SW)) u_rx (
    .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .sync_rise(rxs_rise),
    .lanes_mode(lanes_mode), .din(din), .rx_flat(rx_samples), .rx_valid(rx_valid));

  // R4: a sync edge mid-transmit never drops the enables in the same cycle
  oe_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txs_rise |=> dout_oe[0]);
endmodule

// File: tb/pcm_port_tb_top.sv
`timescale 1ns/1ps
module pcm_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, tx_sync = 1'b0, rx_sync = 1'b0, lanes_mode = 1'b1;
  logic [3:0]  din = 4'h0;
  logic [31:0] tx_samples = 32'h0;
  logic [3:0]  dout, dout_oe;
  logic [31:0] rx_samples;
  logic        rx_valid;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcm_port dut_i (.clk(clk), .rst_n(rst_n), .bclk(bclk), .tx_sync(tx_sync),
    .rx_sync(rx_sync), .lanes_mode(lanes_mode), .din(din), .tx_samples(tx_samples),
    .dout(dout), .dout_oe(dout_oe), .rx_samples(rx_samples), .rx_valid(rx_valid));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Channel 0 first on the line, most significant bit first.
  function automatic logic [31:0] ser(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Monitor: every strobe pops the oldest expected receive word.
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected strobe", rx_samples, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rx_samples === e, "R1 R3 R5 R6 rx data", rx_samples, e);
      end
    end
  end

  task automatic run_frame(input logic par, input int off, input int rs,
                           input logic [31:0] txw, input logic [31:0] rxw, input string tag);
    int len, r0, nb, en_err;
    logic [31:0] act [4];
    len = par ? 8 : 32;
    r0 = rs + off;
    nb = r0 + len + 4;
    en_err = 0;
    for (int l = 0; l < 4; l++) act[l] = '0;
    lanes_mode = par;
    exp_q.push_back(rxw);
    tx_samples = (rs > 0) ? ~txw : txw;
    for (int b = 0; b < nb; b++) begin
      int k;
      @(negedge clk);
      if (b == rs) tx_samples = txw;
      bclk = 1'b1;
      tx_sync = (b == 0 || b == rs);
      rx_sync = (b == off || b == r0);
      k = b - r0;
      if (k >= 0 && k < len) begin
        din = 4'h0;
        if (par) for (int l = 0; l < 4; l++) din[l] = rxw[8*l + 7 - k];
        else din[3] = ser(rxw)[31 - k];
      end else begin
        din = 4'(b) ^ 4'hA;
      end
      repeat (4) @(negedge clk);
      if (b >= rs) begin
        int kt;
        kt = b - rs;
        for (int l = 0; l < 4; l++) begin
          logic want;
          want = (kt < len) && (par || l == 0);
          if (dout_oe[l] !== want) en_err++;
          if (!want && dout[l] !== 1'b1) en_err++;
          if (kt < len) act[l][len - 1 - kt] = dout[l];
        end
      end
      bclk = 1'b0;
      repeat (3) @(negedge clk);
    end
    tx_sync = 1'b0; rx_sync = 1'b0;
    repeat (4) @(negedge clk);
    if (par) begin
      for (int l = 0; l < 4; l++)
        chk(act[l][7:0] === txw[8*l +: 8], {"R1 R2 R5 tx lane ", tag}, {24'h0, act[l][7:0]}, {24'h0, txw[8*l +: 8]});
    end else begin
      chk(act[0] === ser(txw), {"R1 R2 R6 tx tdm ", tag}, act[0], ser(txw));
    end
    chk(en_err == 0, {"R4 R6 enable/release ", tag}, 32'(en_err), 32'h0);
    chk(exp_q.size() == 0, {"R7 R9 strobe count ", tag}, 32'(exp_q.size()), 32'h0);
    chk(rx_samples === rxw, {"R8 R10 held after trailing bits ", tag}, rx_samples, rxw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dout_oe === 4'h0, "R4 reset released", {28'h0, dout_oe}, 32'h0);
    chk(dout === 4'hF, "R4 reset pulled up", {28'h0, dout}, 32'hF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rx_valid === 1'b0 && rx_samples === 32'h0, "R7 reset rx idle", rx_samples, 32'h0);
    run_frame(1'b1, 0, 0, 32'hA53C_0F81, 32'h1E2D_3C4B, "lanes aligned");
    run_frame(1'b1, 3, 0, 32'hFF00_80_01, 32'h0000_FF7E, "lanes offset R10");
    run_frame(1'b0, 0, 0, 32'h8102_4F3A, 32'hC3A5_0180, "tdm aligned");
    run_frame(1'b0, 5, 4, 32'h7E11_E4D2, 32'h5AF0_9966, "tdm restart R9");
    run_frame(1'b1, 2, 3, 32'h0102_0408, 32'hFEDC_BA98, "lanes restart R9");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule